// File: doc/BRIEF.md
# Sixteen-Pin Expander Register Bank

This block is the register core of a 16-pin general-purpose I/O expander. The pins are split into two ports of eight. A simple strobe interface stands in for the serial bus front end. Each request carries a valid bit, a write flag, an 8-bit address and 8-bit write data. Read data comes back one cycle later, marked by a valid flag.

The bank stores these registers:
- per-port output levels, pin direction, interrupt-disable masks and pin mode;
- one global control byte;
- a registered snapshot of the pin levels.

From the stored state it computes each pin's drive level and output enable. Port 0 can be switched between push-pull and open-drain. Port 1 always drives push-pull. A pin placed in the alternate (current-drive) mode simply pulls low.

A read of either input-level address raises a one-cycle pulse that carries the port number. A separate change-detection block uses this pulse. A write of zero to the soft-reset address returns every register to its reset value.

Top module: `gpio16_regbank`

## Requirements
- R1: After reset, these registers read back as follows: direction 0xFF, interrupt-disable 0xFF, output level 0x00, mode 0xFF and global control 0x00. All 16 output enables are low.
- R2: Each register is addressed as follows, with address bit 0 selecting port 0 or port 1:
  - output level at 0x02/0x03;
  - direction at 0x04/0x05;
  - interrupt-disable at 0x06/0x07;
  - mode at 0x12/0x13.
  Each of these registers is writable. A read returns the stored byte on `rd_data` one cycle after the request, with `rd_valid` high in that cycle.
- R3: Addresses 0x00 and 0x01 return pin levels 7:0 and 15:8, as captured by the clock edge before the read request. Writes to these addresses do not change what they return.
- R4: When a pin's direction bit is 1, the pin is an input and its output enable is 0. When the bit is 0, the pin drives its output-level bit with its enable at 1, unless R5 applies. Pin k of port p is bit k of that port's registers and pin p*8+k on the pin buses.
- R5: Bit 4 of global control (0x11) selects the port 0 drive style. When the bit is 0, a port 0 output pin drives 0 with enable high when its level bit is 0, and releases (enable 0, drive 0) when its level bit is 1. When the bit is 1, port 0 is push-pull.
- R6: Port 1 output pins are always push-pull, whatever the value of global control bit 4.
- R7: A mode bit of 0 makes the pin drive 0 with its enable at 1, overriding its direction bit.
- R8: Address 0x10 always reads 0x23. Writes to it are ignored.
- R9: Addresses 0x08–0x0F, 0x14–0x7E and 0x80–0xFF read 0x00. Writes to them change no register.
- R10: Writing 0x00 to address 0x7F restores every register to its R1 value. Writing any other value there has no effect. A read of 0x7F returns 0x00.
- R11: A read of 0x00 or 0x01 raises `in_rd_pulse` for exactly the one cycle in which `rd_valid` is high. In that cycle `in_rd_port` equals address bit 0. No other access raises the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data |
| in_rd_pulse | output | 1 | One-cycle pulse for a read of an input-level register |
| in_rd_port | output | 1 | Port number that goes with in_rd_pulse |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive levels |
| pin_oe | output | 16 | Pin output enables |

## Verification
Read results (`rd_data`, `rd_valid`, `in_rd_pulse` and `in_rd_port`) pass through one register. They are therefore due in the cycle after the request. Pin drive and enable pass only through the configuration registers. They change immediately after the edge that takes a write, so they are also due one cycle after the write strobe.

Input levels go through the snapshot register first. A read sees pins that settled one edge before the read request.

The bench drives every request at a falling edge and holds it for one cycle. It samples all outputs at the next falling edge, which is exactly one rising edge later. It changes `pin_in` at least a full cycle before reading it back.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam logic [7:0] A_IN     = 8'h00;
  localparam logic [7:0] A_ID     = 8'h10;
  localparam logic [7:0] A_GCTL   = 8'h11;
  localparam logic [7:0] A_MODE   = 8'h12;
  localparam logic [7:0] A_SRST   = 8'h7F;
  localparam logic [7:0] ID_VAL   = 8'h23;
  localparam int         OD_BIT   = 4;

  typedef enum logic [2:0] {SEL_NONE, SEL_OUT, SEL_DIR, SEL_IDIS, SEL_MODE} port_sel_e;

  // Which per-port register an address names (port itself is address bit 0)
  function automatic port_sel_e decode_sel(input logic [7:0] a);
    if (a[7:3] == 5'd0) begin
      case (a[2:1])
        2'd1:    return SEL_OUT;
        2'd2:    return SEL_DIR;
        2'd3:    return SEL_IDIS;
        default: return SEL_NONE;
      endcase
    end
    if (a[7:1] == A_MODE[7:1]) return SEL_MODE;
    return SEL_NONE;
  endfunction

  function automatic logic is_hole(input logic [7:0] a);
    return (a >= 8'h08 && a <= 8'h0F) || (a >= 8'h14 && a <= 8'h7E) || (a >= 8'h80);
  endfunction

  // Returns {oe, out} for one pin
  function automatic logic [1:0] drive_pin(input logic is_in, input logic gpio,
                                           input logic lvl, input logic od);
    if (!gpio) return 2'b10;
    if (is_in) return 2'b00;
    if (od)    return {~lvl, 1'b0};
    return {1'b1, lvl};
  endfunction
endpackage

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
  import gpx_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  port_sel_e     wr_sel,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] outv,
  output logic [PW-1:0] dir,
  output logic [PW-1:0] idis,
  output logic [PW-1:0] mode
);
  localparam logic [PW-1:0] ONES = {PW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outv <= '0; dir <= ONES; idis <= ONES; mode <= ONES;
    end else if (soft_rst) begin
      outv <= '0; dir <= ONES; idis <= ONES; mode <= ONES;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_OUT:  outv <= wdata;
        SEL_DIR:  dir  <= wdata;
        SEL_IDIS: idis <= wdata;
        SEL_MODE: mode <= wdata;
        default:  ;
      endcase
    end
  end

  p_soft_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (outv == '0 && dir == ONES && idis == ONES && mode == ONES));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR && !soft_rst) |=> dir == $past(wdata));
endmodule

// File: rtl/gpx_pin_drive.sv
module gpx_pin_drive
  import gpx_pkg::*;
#(
  parameter int PW    = 8,
  parameter bit OD_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] dir,
  input  logic [PW-1:0] mode,
  input  logic [PW-1:0] lvl,
  input  logic          od_sel,
  output logic [PW-1:0] oe,
  output logic [PW-1:0] out
);
  wire od_eff = OD_OK & od_sel;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    assign {oe[i], out[i]} = drive_pin(dir[i], mode[i], lvl[i], od_eff);

    if (OD_OK) begin : g_od
      p_od_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (od_sel && !dir[i] && mode[i] && lvl[i]) |-> (!oe[i] && !out[i]));
    end else begin : g_pp
      p_pushpull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (od_sel && !dir[i] && mode[i]) |-> (oe[i] && out[i] == lvl[i]));
    end

    p_alt_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[i] |-> (oe[i] && !out[i]));
  end
endmodule

// File: rtl/gpio16_regbank.sv
module gpio16_regbank
  import gpx_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [7:0]      req_addr,
  input  logic [PW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [PW-1:0]   rd_data,
  output logic            in_rd_pulse,
  output logic            in_rd_port,
  input  logic [2*PW-1:0] pin_in,
  output logic [2*PW-1:0] pin_out,
  output logic [2*PW-1:0] pin_oe
);
  localparam int NPORT = 2;

  wire wr_go = req_valid & req_write;
  wire rd_go = req_valid & ~req_write;
  wire soft_rst = wr_go && (req_addr == A_SRST) && (req_wdata == '0);
  wire in_rd_evt = rd_go && (req_addr[7:1] == A_IN[7:1]);
  port_sel_e sel;
  assign sel = decode_sel(req_addr);

  logic [PW-1:0] snap_q [NPORT];
  logic [PW-1:0] outv   [NPORT];
  logic [PW-1:0] dir    [NPORT];
  logic [PW-1:0] idis   [NPORT];
  logic [PW-1:0] mode   [NPORT];
  logic [PW-1:0] gctl_q;
  logic [PW-1:0] rd_next;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q[p] <= '0;
      else        snap_q[p] <= pin_in[p*PW +: PW];
    end

    gpx_port_regs #(.PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_go && sel != SEL_NONE && req_addr[0] == 1'(p)),
      .wr_sel(sel), .wdata(req_wdata),
      .outv(outv[p]), .dir(dir[p]), .idis(idis[p]), .mode(mode[p])
    );

    gpx_pin_drive #(.PW(PW), .OD_OK(p == 0)) u_drv (
      .clk(clk), .rst_n(rst_n),
      .dir(dir[p]), .mode(mode[p]), .lvl(outv[p]),
      .od_sel(~gctl_q[OD_BIT]),
      .oe(pin_oe[p*PW +: PW]), .out(pin_out[p*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           gctl_q <= '0;
    else if (soft_rst)                    gctl_q <= '0;
    else if (wr_go && req_addr == A_GCTL) gctl_q <= req_wdata;
  end

  always_comb begin
    rd_next = '0;
    if (req_addr[7:3] == 5'd0) begin
      case (req_addr[2:1])
        2'd0: rd_next = snap_q[req_addr[0]];
        2'd1: rd_next = outv[req_addr[0]];
        2'd2: rd_next = dir[req_addr[0]];
        2'd3: rd_next = idis[req_addr[0]];
        default: rd_next = '0;
      endcase
    end else if (req_addr == A_ID) begin
      rd_next = ID_VAL;
    end else if (req_addr == A_GCTL) begin
      rd_next = gctl_q;
    end else if (req_addr[7:1] == A_MODE[7:1]) begin
      rd_next = mode[req_addr[0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; in_rd_pulse <= 1'b0; in_rd_port <= 1'b0;
    end else begin
      rd_valid    <= rd_go;
      rd_data     <= rd_go ? rd_next : '0;
      in_rd_pulse <= in_rd_evt;
      in_rd_port  <= req_addr[0];
    end
  end

  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_pulse |-> $past(req_valid && !req_write && req_addr[7:1] == 7'd0));

  p_rd_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_pulse |-> (rd_valid && in_rd_port == $past(req_addr[0])));

  p_id_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == A_ID) |=> rd_data == ID_VAL);

  p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_hole(req_addr)) |=> rd_data == '0);

  p_gctl_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == A_SRST && req_wdata != '0) |=> $stable(gctl_q));
endmodule

// File: tb/gpio16_regbank_bench.sv
module gpio16_regbank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic rd_valid, in_rd_pulse, in_rd_port;
  logic [7:0] rd_data;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio16_regbank u_gpio16_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .in_rd_pulse(in_rd_pulse), .in_rd_port(in_rd_port),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d,
                    output logic v, output logic pl, output logic pt);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    d = rd_data; v = rd_valid; pl = in_rd_pulse; pt = in_rd_port;
    req_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v, pl, pt;
    rd(a, d, v, pl, pt);
    chk({tag, " data"}, d, exp);
    chk({tag, " valid"}, v, 1'b1);
  endtask

  task automatic t_reset;
    rd_chk("R1 out0", 8'h02, 8'h00);  rd_chk("R1 out1", 8'h03, 8'h00);
    rd_chk("R1 dir0", 8'h04, 8'hFF);  rd_chk("R1 dir1", 8'h05, 8'hFF);
    rd_chk("R1 idis0", 8'h06, 8'hFF); rd_chk("R1 idis1", 8'h07, 8'hFF);
    rd_chk("R1 gctl", 8'h11, 8'h00);
    rd_chk("R1 mode0", 8'h12, 8'hFF); rd_chk("R1 mode1", 8'h13, 8'hFF);
    chk("R1 oe", pin_oe, 16'h0000);
  endtask

  task automatic t_regs;
    wr(8'h02, 8'h3C); wr(8'h03, 8'hC5); wr(8'h06, 8'h12); wr(8'h07, 8'h81);
    wr(8'h12, 8'hA0); wr(8'h13, 8'h0B); wr(8'h04, 8'h77); wr(8'h05, 8'h5E);
    rd_chk("R2 out0", 8'h02, 8'h3C);  rd_chk("R2 out1", 8'h03, 8'hC5);
    rd_chk("R2 idis0", 8'h06, 8'h12); rd_chk("R2 idis1", 8'h07, 8'h81);
    rd_chk("R2 mode0", 8'h12, 8'hA0); rd_chk("R2 mode1", 8'h13, 8'h0B);
    rd_chk("R2 dir0", 8'h04, 8'h77);  rd_chk("R2 dir1", 8'h05, 8'h5E);
    wr(8'h02, 8'h00); wr(8'h03, 8'h00); wr(8'h06, 8'hFF); wr(8'h07, 8'hFF);
    wr(8'h12, 8'hFF); wr(8'h13, 8'hFF); wr(8'h04, 8'hFF); wr(8'h05, 8'hFF);
  endtask

  task automatic t_inputs;
    logic [7:0] d; logic v, pl, pt;
    @(negedge clk); pin_in = 16'hA55A;
    @(negedge clk);
    rd(8'h00, d, v, pl, pt);
    chk("R3 port0 level", d, 8'h5A);
    chk("R11 pulse p0", pl, 1'b1); chk("R11 port p0", pt, 1'b0);
    rd(8'h01, d, v, pl, pt);
    chk("R3 port1 level", d, 8'hA5);
    chk("R11 pulse p1", pl, 1'b1); chk("R11 port p1", pt, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", in_rd_pulse, 1'b0);
    rd(8'h02, d, v, pl, pt);
    chk("R11 no pulse on other read", pl, 1'b0);
    wr(8'h00, 8'hFF); wr(8'h01, 8'h00);
    rd_chk("R3 write ignored p0", 8'h00, 8'h5A);
    rd_chk("R3 write ignored p1", 8'h01, 8'hA5);
  endtask

  task automatic t_pushpull;
    wr(8'h11, 8'h10); wr(8'h02, 8'hC3); wr(8'h04, 8'h00);
    chk("R4 pp out", pin_out[7:0], 8'hC3);
    chk("R4 pp oe", pin_oe[7:0], 8'hFF);
    wr(8'h04, 8'h0F);
    chk("R4 mixed dir oe", pin_oe[7:0], 8'hF0);
    chk("R4 mixed dir out", pin_out[7:0], 8'hC0);
  endtask

  task automatic t_opendrain;
    wr(8'h04, 8'h00); wr(8'h11, 8'h00);
    chk("R5 od out", pin_out[7:0], 8'h00);
    chk("R5 od oe", pin_oe[7:0], 8'h3C);
    wr(8'h04, 8'hFF); wr(8'h02, 8'h00);
  endtask

  task automatic t_port1;
    wr(8'h03, 8'h96); wr(8'h05, 8'h00);
    chk("R6 p1 out with od", pin_out[15:8], 8'h96);
    chk("R6 p1 oe with od", pin_oe[15:8], 8'hFF);
    wr(8'h05, 8'hFF); wr(8'h03, 8'h00);
  endtask

  task automatic t_mode;
    wr(8'h12, 8'h0F);
    chk("R7 alt oe", pin_oe[7:0], 8'hF0);
    chk("R7 alt out", pin_out[7:0], 8'h00);
    wr(8'h13, 8'hFE); wr(8'h03, 8'h01); wr(8'h05, 8'h00);
    chk("R7 alt overrides level", pin_out[8], 1'b0);
    chk("R7 alt oe p1", pin_oe[8], 1'b1);
    wr(8'h12, 8'hFF); wr(8'h13, 8'hFF); wr(8'h05, 8'hFF); wr(8'h03, 8'h00);
  endtask

  task automatic t_id;
    rd_chk("R8 id", 8'h10, 8'h23);
    wr(8'h10, 8'h55);
    rd_chk("R8 id after write", 8'h10, 8'h23);
  endtask

  task automatic t_holes;
    wr(8'h08, 8'hAA); wr(8'h0E, 8'h00); wr(8'h14, 8'h00);
    wr(8'h7E, 8'hAA); wr(8'h82, 8'h5A); wr(8'h84, 8'h00);
    rd_chk("R9 hole 08", 8'h08, 8'h00); rd_chk("R9 hole 14", 8'h14, 8'h00);
    rd_chk("R9 hole 7E", 8'h7E, 8'h00); rd_chk("R9 hole 82", 8'h82, 8'h00);
    rd_chk("R9 out0 kept", 8'h02, 8'h00); rd_chk("R9 dir0 kept", 8'h04, 8'hFF);
    rd_chk("R9 idis0 kept", 8'h06, 8'hFF); rd_chk("R9 mode0 kept", 8'h12, 8'hFF);
    rd_chk("R9 gctl kept", 8'h11, 8'h00);
  endtask

  task automatic t_softrst;
    wr(8'h02, 8'h11); wr(8'h05, 8'h22); wr(8'h07, 8'h33);
    wr(8'h13, 8'h44); wr(8'h11, 8'h10);
    wr(8'h7F, 8'h01);
    rd_chk("R10 nonzero no effect out0", 8'h02, 8'h11);
    rd_chk("R10 nonzero no effect gctl", 8'h11, 8'h10);
    wr(8'h7F, 8'h00);
    rd_chk("R10 out0", 8'h02, 8'h00);  rd_chk("R10 dir1", 8'h05, 8'hFF);
    rd_chk("R10 idis1", 8'h07, 8'hFF); rd_chk("R10 mode1", 8'h13, 8'hFF);
    rd_chk("R10 gctl", 8'h11, 8'h00);  rd_chk("R10 read 7F", 8'h7F, 8'h00);
    chk("R10 oe", pin_oe, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_regs; t_inputs; t_pushpull; t_opendrain;
    t_port1; t_mode; t_id; t_holes; t_softrst;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule